// File: doc/BRIEF.md
# Programmable Host Watchdog with Latched Output Shutdown

This block supervises a host controller that drives a bank of output channels over a serial link. The host must keep sending active-low service pulses; each valid pulse restarts a timeout counter that advances on a millisecond tick. A 2-bit preset, taken from the quantized level of an analog select pin, either switches the watchdog off or selects one of three timeouts. If the counter reaches the selected limit, the block latches a shutdown state. In that state every channel output is forced off and the stored channel command is cleared.

Only a new service pulse releases the shutdown. After release the outputs stay off until the host writes a fresh channel command. The watchdog runs only while the serial control mode is selected. In parallel mode it is held idle and any latched shutdown is dropped.

Top module: `wdog_supervisor`

## Requirements
- R1: After reset `chan_o` is all zero and `wd_reset_o` is low.
- R2: With `preset_i` = 2'b00 the watchdog is disabled: no number of ticks sets `wd_reset_o`.
- R3: With `preset_i` = 2'b01, 2'b10 or 2'b11 the limit is 40, 80 or 160 ticks. `wd_reset_o` rises on the clock edge that counts the limit-th `ms_tick_i` pulse after the counter was last cleared.
- R4: `service_ni` passes through a two-flop synchronizer. A low level that lasts at least 2 synchronized clocks is one service event, and that event clears the counter. A low lasting 1 clock is ignored.
- R5: While `wd_reset_o` is high, `chan_o` is all zero and `cmd_load_i` has no effect.
- R6: Once set, `wd_reset_o` stays high through further ticks and preset changes between nonzero codes. It is released only by a service event, by leaving serial mode, or by selecting preset 2'b00.
- R7: A change of `preset_i` restarts the count from zero.
- R8: With `serial_mode_i` low the counter is held at zero and `wd_reset_o` stays low.
- R9: After `wd_reset_o` falls, `chan_o` stays zero until the next `cmd_load_i`.
- R10: When not in shutdown, `cmd_load_i` stores `chan_cmd_i`. The stored value appears on `chan_o` after the next clock edge.
- R11: The counter saturates at the selected limit. A continuing tick stream during shutdown does not wrap it or release the shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| serial_mode_i | input | 1 | High when the serial control mode is selected |
| preset_i | input | 2 | Timeout select: 00 off, 01 40 ticks, 10 80 ticks, 11 160 ticks |
| service_ni | input | 1 | Asynchronous active-low service input |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| cmd_load_i | input | 1 | Store `chan_cmd_i` into the channel register |
| chan_cmd_i | input | NCH | Channel on/off command |
| chan_o | output | NCH | Gated channel enables |
| wd_reset_o | output | 1 | Latched watchdog shutdown state |

## Verification
A reference model is compared with the design on every clock. The service input is driven with one-clock glitches and with multi-clock lows. This separates the glitch filter from the clear path, and shows whether a glitch wrongly releases or restarts the count. Expiry is driven with ticks on every cycle and with sparse ticks at each of the three presets, which exposes off-by-one limits and limit-to-code mixups. Preset changes are made mid-count and during shutdown, and there are spells in parallel mode and with the watchdog disabled. Together these separate a reload from a release, and show whether the disable paths truly stop expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'b00,
    WD_SHORT = 2'b01,
    WD_MID   = 2'b10,
    WD_LONG  = 2'b11
  } wd_preset_e;
endpackage

// File: rtl/wdog_svc_filter.sv
module wdog_svc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic svc_ni,
  output logic svc_evt_o
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LW-1:0]          low_run_q;
  logic                   svc_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b1;
          else         sync_q[0] <= svc_ni;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b1;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign svc_s = sync_q[SYNC_STAGES-1];

  // one event per low pulse, fired when the run reaches MIN_LOW
  assign svc_evt_o = !svc_s && (low_run_q == LW'(MIN_LOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         low_run_q <= '0;
    else if (svc_s)                      low_run_q <= '0;
    else if (low_run_q != LW'(MIN_LOW))  low_run_q <= low_run_q + 1'b1;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int T_SHORT = 40,
  parameter int T_MID   = 80,
  parameter int T_LONG  = 160
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic [1:0] preset_i,
  input  logic       svc_evt_i,
  input  logic       tick_i,
  output logic       expired_o
);
  localparam int CW = $clog2(T_LONG + 1);

  logic [CW-1:0] cnt_q, limit;
  logic [1:0]    preset_q;
  logic          exp_q;
  wd_preset_e    sel;

  assign sel = wd_preset_e'(preset_i);

  always_comb begin
    unique case (sel)
      WD_SHORT: limit = CW'(T_SHORT);
      WD_MID:   limit = CW'(T_MID);
      WD_LONG:  limit = CW'(T_LONG);
      default:  limit = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      exp_q    <= 1'b0;
      preset_q <= 2'b00;
    end else begin
      preset_q <= preset_i;
      if (!active_i || sel == WD_OFF) begin
        cnt_q <= '0;
        exp_q <= 1'b0;
      end else if (svc_evt_i) begin
        cnt_q <= '0;
        exp_q <= 1'b0;
      end else if (preset_i != preset_q) begin
        cnt_q <= '0;
      end else if (!exp_q && tick_i) begin
        if ({1'b0, cnt_q} + 1'b1 >= {1'b0, limit}) begin
          cnt_q <= limit;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/wdog_chan_reg.sv
module wdog_chan_reg #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           load_i,
  input  logic [NCH-1:0] cmd_i,
  output logic [NCH-1:0] chan_o
);
  logic [NCH-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (clr_i)  cmd_q <= '0;
    else if (load_i) cmd_q <= cmd_i;
  end

  assign chan_o = cmd_q & {NCH{~clr_i}};
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int NCH     = 8,
  parameter int T_SHORT = 40,
  parameter int T_MID   = 80,
  parameter int T_LONG  = 160,
  parameter int MIN_LOW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           serial_mode_i,
  input  logic [1:0]     preset_i,
  input  logic           service_ni,
  input  logic           ms_tick_i,
  input  logic           cmd_load_i,
  input  logic [NCH-1:0] chan_cmd_i,
  output logic [NCH-1:0] chan_o,
  output logic           wd_reset_o
);
  logic svc_evt;
  logic expired;

  wdog_svc_filter #(.SYNC_STAGES(2), .MIN_LOW(MIN_LOW)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .svc_ni    (service_ni),
    .svc_evt_o (svc_evt)
  );

  wdog_timer #(.T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (serial_mode_i),
    .preset_i  (preset_i),
    .svc_evt_i (svc_evt),
    .tick_i    (ms_tick_i),
    .expired_o (expired)
  );

  wdog_chan_reg #(.NCH(NCH)) u_chan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (expired),
    .load_i (cmd_load_i),
    .cmd_i  (chan_cmd_i),
    .chan_o (chan_o)
  );

  assign wd_reset_o = expired;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           serial_mode_i,
  input logic [1:0]     preset_i,
  input logic           cmd_load_i,
  input logic [NCH-1:0] chan_cmd_i,
  input logic [NCH-1:0] chan_o,
  input logic           wd_reset_o,
  input logic           svc_evt
);
  AST_OFF_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_reset_o |-> chan_o == '0); // R5

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i == 2'b00 |=> !wd_reset_o); // R2

  AST_PARALLEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serial_mode_i |=> !wd_reset_o); // R8

  AST_SVC_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_evt |=> !wd_reset_o); // R4

  AST_RELEASE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wd_reset_o) |-> $past(svc_evt || !serial_mode_i || preset_i == 2'b00)); // R6

  AST_DARK_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wd_reset_o) |-> chan_o == '0); // R9

  AST_CMD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_load_i && !wd_reset_o) |=> (wd_reset_o || chan_o == $past(chan_cmd_i))); // R10
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.NCH(NCH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .serial_mode_i (serial_mode_i),
  .preset_i      (preset_i),
  .cmd_load_i    (cmd_load_i),
  .chan_cmd_i    (chan_cmd_i),
  .chan_o        (chan_o),
  .wd_reset_o    (wd_reset_o),
  .svc_evt       (svc_evt)
);

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           serial_mode_i = 1'b0;
  logic [1:0]     preset_i = 2'b00;
  logic           service_ni = 1'b1;
  logic           ms_tick_i = 1'b0;
  logic           cmd_load_i = 1'b0;
  logic [NCH-1:0] chan_cmd_i = '0;
  logic [NCH-1:0] chan_o;
  logic           wd_reset_o;

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string phase = "R1";
  bit    tick_on = 1'b0;
  int    tick_div = 1;

  // reference model state
  int   m_cnt, m_pp;
  bit   m_rst;
  logic [NCH-1:0] m_q;
  bit   hist[$];

  always #10 clk = ~clk;

  wdog_supervisor #(.NCH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .serial_mode_i(serial_mode_i),
    .preset_i(preset_i), .service_ni(service_ni), .ms_tick_i(ms_tick_i),
    .cmd_load_i(cmd_load_i), .chan_cmd_i(chan_cmd_i),
    .chan_o(chan_o), .wd_reset_o(wd_reset_o)
  );

  function automatic int lim_of(int p);
    return (p == 1) ? 40 : (p == 2) ? 80 : 160;
  endfunction

  task automatic check(bit ok, string req, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = 0; m_pp = 0; m_rst = 0; m_q = '0;
      hist = '{1, 1, 1, 1};
    end else begin
      bit evt, nr; int nc; logic [NCH-1:0] nq;
      evt = !hist[1] && !hist[2] && hist[3];
      nc = m_cnt; nr = m_rst;
      if (!serial_mode_i || preset_i == 0) begin nc = 0; nr = 0; end
      else if (evt) begin nc = 0; nr = 0; end
      else if (int'(preset_i) != m_pp) nc = 0;
      else if (!m_rst && ms_tick_i) begin
        if (m_cnt + 1 >= lim_of(preset_i)) begin nr = 1; nc = lim_of(preset_i); end
        else nc = m_cnt + 1;
      end
      nq = m_rst ? '0 : (cmd_load_i ? chan_cmd_i : m_q);
      m_pp = preset_i; m_cnt = nc; m_rst = nr; m_q = nq;
      hist.push_front(service_ni); void'(hist.pop_back());
    end
    #5;
    if (rst_ni) begin
      logic [NCH-1:0] e_ch;
      e_ch = m_rst ? '0 : m_q;
      check(wd_reset_o === m_rst, phase, $sformatf("rst=%0b", wd_reset_o), $sformatf("rst=%0b", m_rst));
      check(chan_o === e_ch, phase, $sformatf("chan=%h", chan_o), $sformatf("chan=%h", e_ch));
    end
  end

  // tick generator
  always @(negedge clk) begin
    cyc++;
    ms_tick_i <= tick_on && (cyc % tick_div == 0);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic svc_pulse(int low_len);
    @(negedge clk); service_ni = 1'b0;
    wait_cyc(low_len); service_ni = 1'b1;
    wait_cyc(4);
  endtask

  task automatic load(logic [NCH-1:0] v);
    @(negedge clk); chan_cmd_i = v; cmd_load_i = 1'b1;
    @(negedge clk); cmd_load_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        wait_cyc(3);
        phase = "R1";
        check(chan_o == '0, "R1", $sformatf("%h", chan_o), "00");
        check(!wd_reset_o, "R1", $sformatf("%0b", wd_reset_o), "0");
        @(negedge clk); rst_ni = 1'b1;
        wait_cyc(2);
        phase = "R10"; serial_mode_i = 1'b1; preset_i = 2'b01;
        load(8'hA5); wait_cyc(1);
        check(chan_o == 8'hA5, "R10", $sformatf("%h", chan_o), "a5");
        load(8'h3C); wait_cyc(1);
        phase = "R3"; tick_on = 1'b1; tick_div = 1;
        wait_cyc(36);
        check(!wd_reset_o, "R3", "1", "0 before 40 ticks");
        wait_cyc(8);
        check(wd_reset_o, "R3", "0", "1 after 40 ticks");
        phase = "R5"; load(8'hFF); wait_cyc(2);
        check(chan_o == '0, "R5", $sformatf("%h", chan_o), "00");
        phase = "R6"; preset_i = 2'b10; wait_cyc(200);
        check(wd_reset_o, "R6", "0", "1 held");
        phase = "R11"; preset_i = 2'b11; wait_cyc(400);
        check(wd_reset_o, "R11", "0", "1 held, no wrap");
        phase = "R4"; svc_pulse(1);
        check(wd_reset_o, "R4", "0", "1 after glitch");
        svc_pulse(3);
        check(!wd_reset_o, "R4", "1", "0 after pulse");
        phase = "R9"; wait_cyc(3);
        check(chan_o == '0, "R9", $sformatf("%h", chan_o), "00");
        load(8'h81); wait_cyc(1);
        check(chan_o == 8'h81, "R10", $sformatf("%h", chan_o), "81");
        phase = "R4"; preset_i = 2'b10;
        for (int i = 0; i < 6; i++) begin wait_cyc(50); svc_pulse(2); end
        check(!wd_reset_o, "R4", "1", "0 while serviced");
        phase = "R7"; wait_cyc(60); preset_i = 2'b11; wait_cyc(100);
        check(!wd_reset_o, "R7", "1", "0 after reload");
        phase = "R3"; wait_cyc(70);
        check(wd_reset_o, "R3", "0", "1 at 160");
        phase = "R8"; serial_mode_i = 1'b0; wait_cyc(2);
        check(!wd_reset_o, "R8", "1", "0 in parallel mode");
        wait_cyc(300);
        check(!wd_reset_o, "R8", "1", "0 in parallel mode");
        phase = "R2"; preset_i = 2'b00; serial_mode_i = 1'b1; wait_cyc(300);
        check(!wd_reset_o, "R2", "1", "0 when disabled");
        phase = "R3"; tick_div = 3; preset_i = 2'b01; wait_cyc(100);
        check(!wd_reset_o, "R3", "1", "0 before 40 sparse ticks");
        wait_cyc(30);
        check(wd_reset_o, "R3", "0", "1 after 40 sparse ticks");
        wait_cyc(5);
      end
      begin
        wait_cyc(20000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule